// File: doc/BRIEF.md
# Floppy Write Precompensation Delay Selector

This block shifts each outgoing floppy write-data pulse one step earlier, leaves it on time, or shifts it one step later. The shift depends on a 2-bit precompensation code that the disk controller presents with the data. The serial write stream is sampled every clock and fed into a short serial-in parallel-out delay line. The clock runs at the precompensation step rate, nominally 8 MHz for 125 ns steps. Three neighbouring stages of the line serve as the early, nominal and late taps, and the output is taken from the tap that matches the requested shift.

A small capture state machine samples the code and a global enable on the first high cycle of each pulse. It holds the decoded shift for the whole pulse, and the shift travels down the delay line beside the data bits. Each pulse therefore leaves through exactly one tap, even when the code changes while the pulse is in flight. When the enable is low, every pulse takes the nominal tap, so every pulse has the same fixed latency.

Capture state machine: state `ST_IDLE` (the input was low in the previous cycle) moves to `ST_PULSE` when the input is high, and the decoded code and enable are latched on that transition. `ST_PULSE` returns to `ST_IDLE` when the input goes low. In any other cycle the state does not change.

Top module: `wpc_delay_select`

## Requirements
- R1: While `rst_n` is low, `wr_data_out` is 0, and the delay line holds no pulse afterwards.
- R2: With the enable high and code 00 (nominal), an input bit sampled at clock edge t appears on `wr_data_out` after edge t+TAP_EARLY+1 (t+3 with the defaults).
- R3: With the enable high and code 01 (late), the bit appears after edge t+TAP_EARLY+2, one cycle later than nominal.
- R4: With the enable high and code 10 (early), the bit appears after edge t+TAP_EARLY, one cycle sooner than nominal.
- R5: Code 11 is treated exactly like code 00 (nominal delay).
- R6: With the enable low at the start of a pulse, the pulse takes the nominal delay, whatever the code.
- R7: The code and the enable are sampled only in the first high cycle of a pulse (the input was low in the cycle before). Changes to them while the pulse continues have no effect on that pulse.
- R8: Each pulse leaves the block exactly once, with its input width in clock periods kept. Where pulses overlap after shifting, the output is the OR of the shifted pulses.
- R9: Once the input has been low for more than TAP_EARLY+2 cycles, the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step-rate clock (one period per precompensation step) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data_in | input | 1 | Serial write-data stream, sampled every rising edge |
| pc_code | input | 2 | Precompensation code: 00 nominal, 01 late, 10 early, 11 nominal |
| pc_enable | input | 1 | Precompensation on (1) or forced nominal (0) |
| wr_data_out | output | 1 | Shifted write-data stream |

## Verification
An input bit sampled at edge t is due at the output after edge t+2 when early, t+3 when nominal and t+4 when late (default TAP_EARLY of 2). The bench drives inputs on the falling edge and keeps a record of every driven cycle. On the following falling edge it compares the output with the OR of the three tap contributions computed from that record. Each contribution carries the shift that the bench derives from the code and enable seen in the pulse's first cycle. Directed pulses cover each code, the disabled case, a mid-pulse code change and widths of one to four cycles. A seeded random stream then exercises closely spaced and overlapping pulses.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [1:0] {
        SH_NORMAL = 2'd0,
        SH_EARLY  = 2'd1,
        SH_LATE   = 2'd2
    } shift_t;

    typedef struct packed {
        logic   bit_val;
        shift_t tag;
    } stage_t;

    function automatic shift_t decode_shift(input logic [1:0] code, input logic en);
        shift_t s;
        s = SH_NORMAL;
        if (en) begin
            unique case (code)
                2'b01:   s = SH_LATE;
                2'b10:   s = SH_EARLY;
                default: s = SH_NORMAL;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/wpc_capture_fsm.sv
module wpc_capture_fsm
    import wpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_data_in,
    input  logic [1:0] pc_code,
    input  logic       pc_enable,
    output shift_t     tag_now
);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } cap_state_t;

    cap_state_t state_q, state_d;
    shift_t     held_q;
    shift_t     fresh;

    assign fresh = decode_shift(pc_code, pc_enable);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (wr_data_in)  state_d = ST_PULSE;
            ST_PULSE: if (!wr_data_in) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= SH_NORMAL;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && wr_data_in)
                held_q <= fresh;
        end
    end

    // Tag for the bit being sampled at this edge
    always_comb begin
        unique case (state_q)
            ST_IDLE:  tag_now = fresh;
            ST_PULSE: tag_now = held_q;
            default:  tag_now = SH_NORMAL;
        endcase
    end

    // R7: shift held stable while the pulse continues
    a_r7_hold_mid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && wr_data_in) |=> (held_q == $past(held_q)));

    // R6: disabled precompensation latches nominal
    a_r6_disabled_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_data_in && !pc_enable) |=> (held_q == SH_NORMAL));

    // R5: code 11 latches nominal
    a_r5_code11_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_data_in && pc_code == 2'b11) |=> (held_q == SH_NORMAL));

endmodule

// File: rtl/wpc_delay_line.sv
module wpc_delay_line
    import wpc_pkg::*;
#(
    parameter int DEPTH = 5
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t stage_in,
    output stage_t taps [DEPTH]
);

    stage_t sr_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[0] <= '0;
        else        sr_q[0] <= stage_in;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q[i] <= '0;
            else        sr_q[i] <= sr_q[i-1];
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_tap
        assign taps[k] = sr_q[k];
    end

endmodule

// File: rtl/wpc_delay_select.sv
module wpc_delay_select
    import wpc_pkg::*;
#(
    parameter int TAP_EARLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_data_in,
    input  logic [1:0] pc_code,
    input  logic       pc_enable,
    output logic       wr_data_out
);

    localparam int TAP_NORM  = TAP_EARLY + 1;
    localparam int TAP_LATE  = TAP_EARLY + 2;
    localparam int DEPTH     = TAP_LATE + 1;
    localparam int QUIET_LIM = TAP_LATE + 2;
    localparam int QW        = $clog2(QUIET_LIM + 1);

    shift_t tag_now;
    stage_t stage_in;
    stage_t taps [DEPTH];
    logic   hit_early, hit_norm, hit_late;

    wpc_capture_fsm u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_in (wr_data_in),
        .pc_code    (pc_code),
        .pc_enable  (pc_enable),
        .tag_now    (tag_now)
    );

    assign stage_in = '{bit_val: wr_data_in, tag: tag_now};

    wpc_delay_line #(.DEPTH(DEPTH)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_in (stage_in),
        .taps     (taps)
    );

    // Tap multiplexer: each bit leaves only through the tap of its own shift
    always_comb begin
        hit_early = taps[TAP_EARLY].bit_val && (taps[TAP_EARLY].tag == SH_EARLY);
        hit_norm  = taps[TAP_NORM].bit_val  && (taps[TAP_NORM].tag  == SH_NORMAL);
        hit_late  = taps[TAP_LATE].bit_val  && (taps[TAP_LATE].tag  == SH_LATE);
        wr_data_out = hit_early | hit_norm | hit_late;
    end

    // Quiet-window counter for R9
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 quiet_q <= QW'(QUIET_LIM);
        else if (wr_data_in)        quiet_q <= '0;
        else if (quiet_q < QW'(QUIET_LIM)) quiet_q <= quiet_q + 1'b1;
    end

    // R9: no output once the input has been quiet long enough
    a_r9_quiet_output: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q >= QW'(QUIET_LIM - 1)) |-> !wr_data_out);

    // R8: a stage at the late tap with late tag must drive the output
    a_r8_late_emitted: assert property (@(posedge clk) disable iff (!rst_n)
        (taps[TAP_LATE].bit_val && taps[TAP_LATE].tag == SH_LATE) |-> wr_data_out);

endmodule

// File: tb/wpc_delay_select_tb_top.sv
module wpc_delay_select_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TAP_E      = 2;
    localparam int NMAX       = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_data_in = 1'b0;
    logic [1:0] pc_code = 2'b00;
    logic       pc_enable = 1'b1;
    logic       wr_data_out;

    int tests = 0;
    int fails = 0;
    int t = 0;
    bit finished = 0;
    string cur_req = "R2";

    int w_hist   [NMAX];
    int tag_hist [NMAX];

    always #(CLK_PERIOD/2) clk = ~clk;

    wpc_delay_select #(.TAP_EARLY(TAP_E)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_data_in(wr_data_in),
        .pc_code(pc_code), .pc_enable(pc_enable), .wr_data_out(wr_data_out)
    );

    // 0 nominal, 1 early, 2 late
    function automatic int exp_shift(input logic [1:0] c, input logic en);
        if (!en) return 0;
        if (c == 2'b01) return 2;
        if (c == 2'b10) return 1;
        return 0;
    endfunction

    function automatic logic exp_out(input int te);
        logic r;
        r = 1'b0;
        if (te - TAP_E >= 1)
            r = r | (w_hist[te-TAP_E] == 1 && tag_hist[te-TAP_E] == 1);
        if (te - TAP_E - 1 >= 1)
            r = r | (w_hist[te-TAP_E-1] == 1 && tag_hist[te-TAP_E-1] == 0);
        if (te - TAP_E - 2 >= 1)
            r = r | (w_hist[te-TAP_E-2] == 1 && tag_hist[te-TAP_E-2] == 2);
        return r;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0b expected %0b", req, t, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then check after the next rising edge
    task automatic cyc(input logic w, input logic [1:0] c, input logic en);
        int idx;
        wr_data_in = w;
        pc_code    = c;
        pc_enable  = en;
        idx = t + 1;
        w_hist[idx] = w ? 1 : 0;
        if (w && w_hist[idx-1] == 0) tag_hist[idx] = exp_shift(c, en);
        else                         tag_hist[idx] = tag_hist[idx-1];
        @(posedge clk);
        t = idx;
        @(negedge clk);
        check(cur_req, wr_data_out, exp_out(t));
    endtask

    task automatic pulse(input int width, input logic [1:0] c, input logic en, input int gap);
        for (int i = 0; i < width; i++) cyc(1'b1, c, en);
        for (int i = 0; i < gap; i++)   cyc(1'b0, c, en);
    endtask

    initial begin
        int seed;
        for (int i = 0; i < NMAX; i++) begin w_hist[i] = 0; tag_hist[i] = 0; end
        seed = 1234;
        void'($urandom(seed));
        wr_data_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", wr_data_out, 1'b0);
        wr_data_in = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        for (int i = 0; i < 4; i++) cyc(1'b0, 2'b00, 1'b1);

        cur_req = "R2"; pulse(2, 2'b00, 1'b1, 8);
        cur_req = "R3"; pulse(2, 2'b01, 1'b1, 8);
        cur_req = "R4"; pulse(2, 2'b10, 1'b1, 8);
        cur_req = "R5"; pulse(2, 2'b11, 1'b1, 8);
        cur_req = "R6"; pulse(2, 2'b01, 1'b0, 8);
        pulse(2, 2'b10, 1'b0, 8);
        cur_req = "R7";
        cyc(1'b1, 2'b01, 1'b1);
        cyc(1'b1, 2'b10, 1'b1);
        cyc(1'b1, 2'b10, 1'b0);
        for (int i = 0; i < 8; i++) cyc(1'b0, 2'b10, 1'b1);
        cur_req = "R8";
        pulse(1, 2'b01, 1'b1, 6);
        pulse(4, 2'b10, 1'b1, 6);
        pulse(2, 2'b01, 1'b1, 1);
        pulse(2, 2'b10, 1'b1, 8);

        cur_req = "R9";
        for (int i = 0; i < 1500; i++) begin
            logic w;
            logic [1:0] c;
            logic en;
            w  = ($urandom % 3) == 0;
            c  = 2'($urandom % 4);
            en = ($urandom % 5) != 0;
            cyc(w, c, en);
        end
        for (int i = 0; i < 8; i++) cyc(1'b0, 2'b00, 1'b1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule